// File: doc/BRIEF.md
# Multi-stream sample frame packer

This block gathers the per-sample results of up to eight acquisition streams and turns each sample period into one frame of 32-bit words on a valid/ready output. The words go to a downstream FIFO. Each result word is 32 bits wide and comes from a serial-bus master. Every stream has a fixed number of result slots. The serial-bus masters present all their results in parallel, and they hold them stable until the next sample strobe.

A frame is built in this order:
- a fixed 64-bit marker, sent as two words;
- a 32-bit sample timestamp;
- the result words, ordered by slot first and then by ascending stream number, with disabled streams left out completely;
- one final word holding the 16 digital input lines.

The enable mask, the digital inputs and the timestamp are captured on the strobe that starts the frame. A strobe that arrives while a frame is still being sent is dropped, and a sticky overrun flag records it.

Top module: `fp_frame_packer`

## Requirements
- R1: After reset `out_valid` and `overrun` are 0, and the first accepted frame carries timestamp 0.
- R2: Every frame starts with word `32'hA5C3_0F1E` followed by word `32'h5A3C_F0E1`, then the timestamp word.
- R3: The timestamp equals the number of `sample_tick` pulses seen since reset before the one that started the frame. Dropped strobes are included in this count.
- R4: Result words follow the timestamp with the slot index as the outer loop (0 first) and enabled streams in ascending order as the inner loop. The word for stream s, slot k is `slot_words[(k*NUM_STREAMS+s)*32 +: 32]`.
- R5: A stream whose bit in `stream_en` is 0 adds no words, so a frame has 4 + NUM_SLOTS × popcount(mask) words and `out_valid` falls after the last one.
- R6: The last word of each frame is `{16'h0000, din}`, with `din` sampled on the accepted strobe.
- R7: `stream_en` and `din` are sampled only on the accepted strobe. Changing them during a frame does not change that frame's words.
- R8: A word is consumed only in a cycle with `out_valid` and `out_ready` both 1. While `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R9: A `sample_tick` that arrives while a frame is in progress sets `overrun` on the next cycle and starts no frame. `overrun` then stays 1 until reset.
- R10: With `stream_en` all zero, the frame is exactly marker, marker, timestamp and inputs word.
- R11: A strobe asserted in the cycle just after the last word's handshake is accepted without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stream_en | input | NUM_STREAMS | Per-stream enable, sampled at frame start |
| slot_words | input | NUM_STREAMS*NUM_SLOTS*32 | All result words; slot k, stream s at bit (k*NUM_STREAMS+s)*32 |
| din | input | DIN_W | Digital input lines |
| sample_tick | input | 1 | One-cycle sample-period strobe |
| out_data | output | 32 | Current frame word |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | Downstream accepts the word |
| overrun | output | 1 | Sticky: a strobe was dropped |

## Verification
The fault that matters most is a cursor that stands on the wrong stream or slot. It shows up at the ports at the first result word after the fault: the word comes from the wrong position in `slot_words`, or the frame comes out longer or shorter than 4 + NUM_SLOTS × popcount. Because the bench fills every result with a distinct random value, any misplacement changes the very next compared word. A timestamp or overrun state that has gone wrong shows up in the third word of the next frame, or in the flag one cycle after an overlapping strobe.

// File: rtl/fp_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the frame packer: word width and frame phases.
package fp_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MAGIC_HI,
        PH_MAGIC_LO,
        PH_STAMP,
        PH_RESULT,
        PH_INPUTS
    } phase_t;
endpackage

// File: rtl/fp_stamp.sv
`timescale 1ns/1ps
// Sample counter and overrun detector.
// Counts every sample_tick. Grants a frame start only when no frame is busy.
// Assumes sample_tick is a single-cycle pulse.
module fp_stamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic            busy,
    output logic            accept,
    output logic [TS_W-1:0] count,
    output logic            overrun
);
    assign accept = strobe && !busy;

    // Advance the sample count on every strobe and remember any collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (strobe) count <= count + 1'b1;
            if (strobe && busy) overrun <= 1'b1;
        end
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    a_r9_set_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && busy) |=> overrun);
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/fp_cursor.sv
`timescale 1ns/1ps
// Result cursor: walks slot-major / stream-minor over the enabled streams.
// It jumps straight to the next enabled stream, so no cycles are lost on
// disabled ones. Assumes step is given only while a result word is offered.
module fp_cursor #(
    parameter int NUM_STREAMS = 8,
    parameter int NUM_SLOTS   = 20,
    localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int KW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [NUM_STREAMS-1:0] load_mask,
    input  logic                   step,
    output logic [KW-1:0]          slot,
    output logic [SW-1:0]          stream,
    output logic                   last
);
    logic [NUM_STREAMS-1:0] mask_q;
    logic [NUM_STREAMS-1:0] above;
    logic                   has_next;

    function automatic logic [SW-1:0] lowest_set(input logic [NUM_STREAMS-1:0] m);
        lowest_set = '0;
        for (int i = NUM_STREAMS - 1; i >= 0; i--)
            if (m[i]) lowest_set = SW'(i);
    endfunction

    // Enabled streams strictly above the current one.
    always_comb begin
        above    = mask_q & ({NUM_STREAMS{1'b1}} << (int'(stream) + 1));
        has_next = |above;
    end

    assign last = (slot == KW'(NUM_SLOTS - 1)) && !has_next;

    // Load the mask at frame start, then advance one enabled word per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            slot   <= '0;
            stream <= '0;
        end else if (load) begin
            mask_q <= load_mask;
            slot   <= '0;
            stream <= lowest_set(load_mask);
        end else if (step) begin
            if (has_next) begin
                stream <= lowest_set(above);
            end else begin
                slot   <= slot + 1'b1;
                stream <= lowest_set(mask_q);
            end
        end
    end

    a_r5_on_enabled_stream: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> mask_q[stream]);
    a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (int'(slot) < NUM_SLOTS));
    a_r7_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mask_q));
endmodule

// File: rtl/fp_word_mux.sv
`timescale 1ns/1ps
// Selects the word offered on the output for the current frame phase.
// Purely combinational. Assumes slot/stream are in range during PH_RESULT.
module fp_word_mux
    import fp_pkg::*;
#(
    parameter int          NUM_STREAMS = 8,
    parameter int          NUM_SLOTS   = 20,
    parameter int          DIN_W       = 16,
    parameter logic [63:0] MAGIC       = 64'hA5C3_0F1E_5A3C_F0E1,
    localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int KW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int RW = NUM_STREAMS * NUM_SLOTS * WORD_W
) (
    input  phase_t            phase,
    input  logic [WORD_W-1:0] stamp,
    input  logic [DIN_W-1:0]  din_q,
    input  logic [RW-1:0]     slot_words,
    input  logic [KW-1:0]     slot,
    input  logic [SW-1:0]     stream,
    output logic [WORD_W-1:0] word
);
    // Pick the frame word for the present phase.
    always_comb begin
        unique case (phase)
            PH_MAGIC_HI: word = MAGIC[63:32];
            PH_MAGIC_LO: word = MAGIC[31:0];
            PH_STAMP:    word = stamp;
            PH_RESULT:   word = slot_words[(int'(slot) * NUM_STREAMS + int'(stream)) * WORD_W +: WORD_W];
            PH_INPUTS:   word = WORD_W'(din_q);
            default:     word = '0;
        endcase
    end
endmodule

// File: rtl/fp_frame_packer.sv
`timescale 1ns/1ps
// Frame packer top: on each accepted sample strobe it emits
// marker, marker, timestamp, enabled results (slot-major), inputs word.
// Assumes slot_words stays stable from the strobe to the end of the frame.
module fp_frame_packer
    import fp_pkg::*;
#(
    parameter int          NUM_STREAMS = 8,
    parameter int          NUM_SLOTS   = 20,
    parameter int          DIN_W       = 16,
    parameter logic [63:0] MAGIC       = 64'hA5C3_0F1E_5A3C_F0E1,
    localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int KW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int RW = NUM_STREAMS * NUM_SLOTS * WORD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_STREAMS-1:0] stream_en,
    input  logic [RW-1:0]          slot_words,
    input  logic [DIN_W-1:0]       din,
    input  logic                   sample_tick,
    output logic [WORD_W-1:0]      out_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic                   overrun
);
    phase_t              phase, phase_n;
    logic                busy, accept, fire, last, any_en_q;
    logic [WORD_W-1:0]   count, stamp_q;
    logic [DIN_W-1:0]    din_q;
    logic [KW-1:0]       slot;
    logic [SW-1:0]       stream;

    assign busy      = (phase != PH_IDLE);
    assign out_valid = busy;
    assign fire      = out_valid && out_ready;

    fp_stamp #(.TS_W(WORD_W)) u_stamp (
        .clk(clk), .rst_n(rst_n), .strobe(sample_tick), .busy(busy),
        .accept(accept), .count(count), .overrun(overrun)
    );

    fp_cursor #(.NUM_STREAMS(NUM_STREAMS), .NUM_SLOTS(NUM_SLOTS)) u_cursor (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_mask(stream_en),
        .step(fire && (phase == PH_RESULT)), .slot(slot), .stream(stream), .last(last)
    );

    fp_word_mux #(.NUM_STREAMS(NUM_STREAMS), .NUM_SLOTS(NUM_SLOTS),
                  .DIN_W(DIN_W), .MAGIC(MAGIC)) u_mux (
        .phase(phase), .stamp(stamp_q), .din_q(din_q), .slot_words(slot_words),
        .slot(slot), .stream(stream), .word(out_data)
    );

    // Next frame phase, advancing on each handshake.
    always_comb begin
        phase_n = phase;
        unique case (phase)
            PH_IDLE:     if (accept) phase_n = PH_MAGIC_HI;
            PH_MAGIC_HI: if (fire) phase_n = PH_MAGIC_LO;
            PH_MAGIC_LO: if (fire) phase_n = PH_STAMP;
            PH_STAMP:    if (fire) phase_n = any_en_q ? PH_RESULT : PH_INPUTS;
            PH_RESULT:   if (fire && last) phase_n = PH_INPUTS;
            PH_INPUTS:   if (fire) phase_n = PH_IDLE;
            default:     phase_n = PH_IDLE;
        endcase
    end

    // Phase register and per-frame captures taken at the accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            stamp_q  <= '0;
            din_q    <= '0;
            any_en_q <= 1'b0;
        end else begin
            phase <= phase_n;
            if (accept) begin
                stamp_q  <= count;
                din_q    <= din;
                any_en_q <= |stream_en;
            end
        end
    end

    a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r2_marker_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MAGIC_HI && fire) |=> (phase == PH_MAGIC_LO));
    a_r10_no_results: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STAMP && fire && !any_en_q) |=> (phase == PH_INPUTS));
    a_r6_inputs_close: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INPUTS && fire && !sample_tick) |=> !out_valid);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sample_tick && !fire) |=> (out_valid && $stable(phase)));
endmodule

// File: tb/fp_frame_packer_test.sv
`timescale 1ns/1ps
module fp_frame_packer_test;
    localparam int NS  = 8;
    localparam int NSL = 20;
    localparam logic [63:0] MAGIC = 64'hA5C3_0F1E_5A3C_F0E1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     stream_en = '0;
    logic [NS*NSL*32-1:0] slot_words;
    logic [15:0]       din = '0;
    logic              sample_tick = 1'b0;
    logic [31:0]       out_data;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic              overrun;

    logic [31:0] rw [NSL][NS];
    int checks = 0;
    int fails  = 0;
    int ticks  = 0;
    int unused_seed;

    always #5 clk = ~clk;

    always_comb
        for (int k = 0; k < NSL; k++)
            for (int s = 0; s < NS; s++)
                slot_words[(k*NS+s)*32 +: 32] = rw[k][s];

    fp_frame_packer uut (
        .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .slot_words(slot_words),
        .din(din), .sample_tick(sample_tick), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic refill();
        for (int k = 0; k < NSL; k++)
            for (int s = 0; s < NS; s++)
                rw[k][s] = $urandom;
    endtask

    // Expected word idx of a frame, from the requirements.
    function automatic logic [31:0] exp_word(input int idx, input logic [NS-1:0] m,
                                              input logic [15:0] d, input logic [31:0] ts);
        int pc, r, k, nth, seen;
        pc = $countones(m);
        if (idx == 0) return MAGIC[63:32];
        if (idx == 1) return MAGIC[31:0];
        if (idx == 2) return ts;
        if (idx < 3 + pc*NSL) begin
            r = idx - 3; k = r / pc; nth = r % pc; seen = 0;
            for (int s = 0; s < NS; s++)
                if (m[s]) begin
                    if (seen == nth) return rw[k][s];
                    seen++;
                end
        end
        return {16'h0000, d};
    endfunction

    function automatic string tag_of(input int idx, input int len, input bit first);
        if (idx < 2) return "R2";
        if (idx == 2) return first ? "R1" : "R3";
        if (idx == len - 1) return "R6";
        return "R4";
    endfunction

    // Runs one frame. Called just after a rising edge; returns the same way.
    task automatic run_frame(input logic [NS-1:0] m, input logic [15:0] d, input int ready_pct,
                             input bit disturb, input bit extra, input bit chain, input bit first);
        int idx, len, guard;
        logic [31:0] ts, held;
        bit stalled;
        stream_en = m; din = d; sample_tick = 1'b1;
        ts = 32'(ticks); ticks++;
        @(posedge clk); #1 sample_tick = 1'b0;
        if (disturb) begin stream_en = ~m; din = ~d; end  // R7: late changes ignored
        if (extra) begin
            out_ready = 1'b0; sample_tick = 1'b1; ticks++;
            @(posedge clk); #1 sample_tick = 1'b0;
            check(overrun == 1'b1, "R9", 32'(overrun), 32'd1);
        end
        len = 4 + NSL * $countones(m);
        idx = 0; guard = 0; stalled = 0; held = '0;
        while (idx < len && guard < 5000) begin
            out_ready = (int'($urandom % 100) < ready_pct);
            @(negedge clk);
            check(out_valid == 1'b1, "R8", 32'(out_valid), 32'd1);
            if (stalled) check(out_data == held, "R8", out_data, held);
            if (out_ready) begin
                check(out_data == exp_word(idx, m, d, ts), tag_of(idx, len, first),
                      out_data, exp_word(idx, m, d, ts));
                idx++; stalled = 0;
            end else begin
                stalled = 1; held = out_data;
            end
            guard++;
            @(posedge clk); #1;
        end
        check(guard < 5000, "R5", 32'(idx), 32'(len));
        out_ready = 1'b0;
        if (!chain) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R5", 32'(out_valid), 32'd0);
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #1_500_000;
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        unused_seed = $urandom(32'h1F2E3D4C);
        refill();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
        check(overrun == 1'b0, "R1", 32'(overrun), 32'd0);
        @(posedge clk); #1;

        run_frame(8'hFF, 16'hBEEF, 100, 0, 0, 0, 1);   // R1 first stamp 0, R4 full order
        run_frame(8'h00, 16'h1234, 70, 0, 0, 0, 0);    // R10 empty mask
        run_frame(8'h80, 16'h0F0F, 50, 0, 0, 0, 0);    // R5 single high stream
        run_frame(8'h01, 16'hF0F0, 50, 0, 0, 0, 0);    // R5 single low stream
        refill();
        run_frame(8'h5A, 16'hA5A5, 40, 1, 0, 0, 0);    // R7 disturbed mask and inputs
        run_frame(8'hC3, 16'h0001, 100, 0, 0, 1, 0);   // R11 chained frames
        run_frame(8'h24, 16'h8000, 100, 0, 0, 0, 0);
        check(overrun == 1'b0, "R11", 32'(overrun), 32'd0);
        run_frame(8'h99, 16'h7777, 60, 0, 1, 0, 0);    // R9 overlapping strobe dropped
        for (int n = 0; n < 18; n++) begin
            refill();
            run_frame(8'($urandom), 16'($urandom), 30 + int'($urandom % 71), 1'($urandom), 0, 0, 0);
        end
        check(overrun == 1'b1, "R9", 32'(overrun), 32'd1); // sticky
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule